// File: doc/BRIEF.md
# FIFO Threshold Flag and DMA Request Generator

This block sits beside the 32-byte data buffer of a serial memory controller and watches its fill level during indirect transfers. It keeps its own occupancy count from per-cycle push and pop strobes. It compares a direction-dependent byte count against a programmable 5-bit threshold and raises a registered threshold flag. When the host writes to the memory, the count is the free space in the buffer. When the host reads from the memory, the count is the number of valid bytes.

The flag drives a request/acknowledge handshake toward a DMA engine and an interrupt line that has its own enable. The request drops without waiting for an acknowledge when the block is disabled. It also drops when the mode or the threshold changes. In the two non-indirect modes (status polling and memory mapped), the flag and the request stay inactive.

Top module: `fifo_thr_dma`

## Requirements
- R1: After reset the flag, the DMA request and the interrupt are low, and the occupancy is zero.
- R2: In write mode (mode_i = 0), the flag is set when the free bytes (32 minus occupancy) are at least thresh_i + 1.
- R3: In read mode (mode_i = 1), the flag is set when the occupancy is at least thresh_i + 1.
- R4: With mode_i = 2 or 3, or with enable_i low, the flag is low.
- R5: The occupancy saturates at 32 on a push and at 0 on a pop. A push and a pop in the same cycle leave it unchanged.
- R6: The flag is registered. A level change at one clock edge shows on thr_flag_o after the next edge.
- R7: The request rises one cycle after the flag is seen high, provided enable_i and dma_en_i are high and the mode is 0 or 1.
- R8: An acknowledge while the request is high drops the request for at least one cycle.
- R9: With enable_i low, dma_req_o is low in the same cycle, with no acknowledge needed.
- R10: A change of mode_i or thresh_i forces dma_req_o low at once and for the following cycle.
- R11: irq_o is high only when thr_flag_o and irq_en_i are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable |
| dma_en_i | input | 1 | DMA handshake enable |
| mode_i | input | 2 | 0 write, 1 read, 2 polling, 3 memory mapped |
| thresh_i | input | 5 | Threshold N: flag needs N+1 qualifying bytes |
| push_i | input | 1 | One byte entered the buffer |
| pop_i | input | 1 | One byte left the buffer |
| dma_ack_i | input | 1 | DMA acknowledge |
| irq_en_i | input | 1 | Threshold interrupt enable |
| thr_flag_o | output | 1 | Registered threshold flag |
| dma_req_o | output | 1 | DMA request |
| irq_o | output | 1 | Threshold interrupt |

## Verification
The bench sweeps every threshold in both indirect directions while filling past full and draining past empty. A swapped direction, an off-by-one compare (N instead of N+1) or a wrapping counter shows up as a wrong flag at one exact level. It times the flag one edge after the level change, so a flag without its register, or with an extra one, fails. Directed cases drop the request by acknowledge, by disable and by a threshold change. A design that waited for an acknowledge, or that re-requested in the cycle right after one, would keep dma_req_o high where low is expected.

// File: rtl/fthr_pkg.sv
package fthr_pkg;
  typedef enum logic [1:0] {
    MODE_WR   = 2'd0,
    MODE_RD   = 2'd1,
    MODE_POLL = 2'd2,
    MODE_MAP  = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/fthr_level.sv
module fthr_level #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else begin
      unique case ({push_i, pop_i})
        2'b10:   if (level_q != FULL) level_q <= level_q + 1'b1;
        2'b01:   if (level_q != '0)   level_q <= level_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign level_o = level_q;

  // R5
  level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= FULL);
  // R5
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && level_q == FULL) |=> level_q == FULL);
  // R5
  both_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(level_q));
endmodule

// File: rtl/fthr_cmp.sv
module fthr_cmp
  import fthr_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [1:0]       mode_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             flag_o
);
  logic [LVL_W-1:0] qual;
  logic [LVL_W-1:0] need;
  logic             hit;
  logic             flag_q;

  // free space when writing, valid bytes when reading
  assign qual = (xfer_mode_e'(mode_i) == MODE_WR) ? LVL_W'(DEPTH) - level_i : level_i;
  assign need = LVL_W'(thresh_i) + 1'b1;
  assign hit  = enable_i && !mode_i[1] && (qual >= need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= hit;
  end

  assign flag_o = flag_q;

  // R4
  idle_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i || mode_i[1]) |=> !flag_o);
endmodule

// File: rtl/fthr_dreq.sv
module fthr_dreq #(
  parameter int THR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             dma_en_i,
  input  logic [1:0]       mode_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic             flag_i,
  input  logic             ack_i,
  output logic             req_o
);
  logic [1:0]       mode_q;
  logic [THR_W-1:0] thresh_q;
  logic             cfg_chg;
  logic             req_q;
  logic             req_d;

  assign cfg_chg = (mode_i != mode_q) || (thresh_i != thresh_q);

  always_comb begin
    req_d = flag_i;
    if (!enable_i || !dma_en_i || mode_i[1] || cfg_chg) req_d = 1'b0;
    else if (req_q && ack_i)                            req_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      mode_q   <= '0;
      thresh_q <= '0;
    end else begin
      req_q    <= req_d;
      mode_q   <= mode_i;
      thresh_q <= thresh_i;
    end
  end

  // drop without waiting for acknowledge
  assign req_o = req_q && enable_i && dma_en_i && !cfg_chg;

  // R8
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && ack_i) |=> !req_o);
  // R10
  cfg_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_chg |-> !req_o ##1 !req_o);
endmodule

// File: rtl/fifo_thr_dma.sv
module fifo_thr_dma #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             dma_en_i,
  input  logic [1:0]       mode_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             dma_ack_i,
  input  logic             irq_en_i,
  output logic             thr_flag_o,
  output logic             dma_req_o,
  output logic             irq_o
);
  logic [LVL_W-1:0] level;
  logic             flag;

  fthr_level #(.DEPTH(DEPTH)) u_level (
    .clk_i, .rst_ni, .push_i, .pop_i, .level_o(level)
  );

  fthr_cmp #(.DEPTH(DEPTH)) u_cmp (
    .clk_i, .rst_ni, .enable_i, .mode_i, .thresh_i,
    .level_i(level), .flag_o(flag)
  );

  fthr_dreq #(.THR_W(THR_W)) u_dreq (
    .clk_i, .rst_ni, .enable_i, .dma_en_i, .mode_i, .thresh_i,
    .flag_i(flag), .ack_i(dma_ack_i), .req_o(dma_req_o)
  );

  assign thr_flag_o = flag;
  assign irq_o      = flag && irq_en_i;

  // R9
  disable_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !dma_req_o);
  // R11
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && thr_flag_o));
  // R7
  req_needs_dma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (dma_en_i && !mode_i[1]));
endmodule

// File: tb/fifo_thr_dma_tb_top.sv
`timescale 1ns/1ps
module fifo_thr_dma_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, dma = 0, push = 0, pop = 0, ack = 0, ien = 0;
  logic [1:0] mode = 0;
  logic [4:0] th = 0;
  logic flag_o, req_o, irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag_f = "R2", tag_r = "R7";

  // bench model state
  int lvl_m = 0;
  bit flag_m = 0, req_m = 0;
  int mode_m = 0, th_m = 0;

  always #4 clk = ~clk;

  fifo_thr_dma dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .dma_en_i(dma),
    .mode_i(mode), .thresh_i(th), .push_i(push), .pop_i(pop),
    .dma_ack_i(ack), .irq_en_i(ien),
    .thr_flag_o(flag_o), .dma_req_o(req_o), .irq_o(irq_o)
  );

  function automatic bit cfg_diff();
    return (int'(mode) != mode_m) || (int'(th) != th_m);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      lvl_m = 0; flag_m = 0; req_m = 0; mode_m = 0; th_m = 0;
    end else begin
      int q;
      bit nf, nr;
      q  = (mode == 2'd0) ? 32 - lvl_m : lvl_m;
      nf = en && (mode < 2) && (q >= int'(th) + 1);
      nr = en && dma && (mode < 2) && !cfg_diff() && !(req_m && ack) && flag_m;
      if (push && !pop && lvl_m < 32) lvl_m++;
      else if (pop && !push && lvl_m > 0) lvl_m--;
      flag_m = nf; req_m = nr; mode_m = mode; th_m = th;
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(tag_f, flag_o, flag_m);
    chk(tag_r, req_o, req_m && en && dma && !cfg_diff());
    chk("R11", irq_o, flag_m && ien);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic drain();
    push = 0; pop = 1;
    repeat (34) tick();
    pop = 0;
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1", flag_o, 1'b0);
    chk("R1", req_o, 1'b0);
    chk("R1", irq_o, 1'b0);
    rst_n = 1;
    en = 1;
    tick();
    // R1: empty after reset, read mode threshold 0 shows no valid byte
    mode = 1; tick(); tick();
    chk("R1", flag_o, 1'b0);

    // sweep both directions, every threshold, full fill and drain
    dma = 1;
    for (int m = 0; m < 2; m++) begin
      tag_f = (m == 0) ? "R2" : "R3";
      for (int t = 0; t < 32; t++) begin
        mode = m[1:0]; th = t[4:0]; ien = t[0];
        push = 1; pop = 0;
        for (int i = 0; i < 34; i++) begin ack = (i % 3 == 0); tick(); end
        push = 0; pop = 1;
        for (int i = 0; i < 34; i++) begin ack = (i % 4 == 1); tick(); end
        pop = 0; ack = 0;
        tick();
      end
    end

    // R5 saturation at full and empty
    tag_f = "R5"; dma = 0;
    mode = 1; th = 31; tick();
    push = 1; repeat (40) tick();
    push = 0; tick();
    chk("R5", flag_o, 1'b1);
    push = 1; pop = 1; tick(); tick();
    chk("R5", flag_o, 1'b1);
    push = 0; pop = 1; tick(); pop = 0; tick();
    chk("R5", flag_o, 1'b0);
    pop = 1; repeat (40) tick(); pop = 0;
    th = 0; tick(); tick();
    // R6 one-edge latency after the level change
    tag_f = "R6";
    push = 1; tick(); push = 0;
    chk("R6", flag_o, 1'b0);
    tick();
    chk("R6", flag_o, 1'b1);
    chk("R5", flag_o, 1'b1);

    // R7 / R8 request and acknowledge
    tag_f = "R3"; tag_r = "R7";
    dma = 1; tick(); tick();
    chk("R7", req_o, 1'b1);
    tag_r = "R8";
    ack = 1; tick(); ack = 0;
    chk("R8", req_o, 1'b0);
    tick();
    chk("R8", req_o, 1'b1);

    // R9 disable drops at once
    tag_r = "R9";
    en = 0; #1;
    chk("R9", req_o, 1'b0);
    tick();
    chk("R9", req_o, 1'b0);
    en = 1; tick(); tick(); tick();
    chk("R7", req_o, 1'b1);

    // R10 threshold change drops at once and the next cycle
    tag_r = "R10";
    push = 1; tick(); push = 0; tick(); tick();
    th = 1; #1;
    chk("R10", req_o, 1'b0);
    tick();
    chk("R10", req_o, 1'b0);
    tick();
    chk("R10", req_o, 1'b1);
    mode = 0; #1;
    chk("R10", req_o, 1'b0);
    mode = 1; tick(); tick(); tick();

    // R4 non-indirect modes and disable hold the flag low
    tag_f = "R4"; tag_r = "R7";
    mode = 2; tick(); tick();
    chk("R4", flag_o, 1'b0);
    chk("R7", req_o, 1'b0);
    mode = 3; tick(); tick();
    chk("R4", flag_o, 1'b0);
    mode = 1; en = 0; tick(); tick();
    chk("R4", flag_o, 1'b0);
    en = 1; ien = 1; tick(); tick();
    chk("R11", irq_o, 1'b1);
    ien = 0; #1;
    chk("R11", irq_o, 1'b0);
    tag_f = "R3";
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule